// File: doc/BRIEF.md
# Reset and Wake-up Sequencer

This block merges the two chip reset sources, an external reset pin and a watchdog request, into one internal reset. That internal reset keeps the processor stopped until four things are true at once. The pin must be released after a glitch filter. The oscillator must report that it is valid. A fixed number of oscillator-valid clocks must have passed. The flash controller must report that its initialization is done. When the internal reset is released, the block gives a one-cycle pulse that tells the core to start fetching from address 0. A small register records which source caused the most recent reset.

The same timer also guards the exit from power-down. A power-down request stops the core without resetting it. A wake event then runs the same oscillator-valid clock count before the core may run again. This path does not restart the flash and does not force the fetch address to zero. The oscillator state arrives as a digital flag. Analog detection is done outside the block.

Top module: `rst_wake_seq`

## Requirements
- R1: While `por_n` is low, and afterwards until a release, `sys_rst_n` is 0 and `cpu_hold` is 1. After power-on, `cause` reads 2'b00 and `flash_start` is 0.
- R2: A low pulse on `pin_rst_n` that lasts fewer than 4 consecutive clock samples is ignored, so `sys_rst_n` stays 1. A low pulse of 4 samples or more drives `sys_rst_n` to 0.
- R3: `sys_rst_n` stays 0 for as long as `pin_rst_n` is held low.
- R4: Once the filtered pin is high, the wake timer counts only in cycles where `osc_ok` is 1. `flash_start` pulses after exactly `WAKE_CNT` such cycles. While `osc_ok` is 0, no progress is made. A `pd_req` during the sequence has no effect on the count.
- R5: `flash_start` is a single-cycle pulse. The release waits for `flash_done`, and a `flash_done` that is high in the same cycle as the `flash_start` pulse is not accepted.
- R6: On release, `sys_rst_n` rises and `cpu_hold` falls in the same cycle, and `vec_zero` is 1 for exactly that one cycle.
- R7: A one-cycle `wdt_rst` drives `sys_rst_n` to 0 in the next cycle from any state, including power-down. It restarts the sequence, so `flash_start` follows `WAKE_CNT`+2 cycles after the request.
- R8: `cause` holds the most recent reset source and keeps it after release. The encoding is 2'b01 for the pin and 2'b10 for the watchdog. If both arrive in the same cycle, the pin wins.
- R9: A `pd_req` while running raises `cpu_hold` in the next cycle and leaves `sys_rst_n` at 1.
- R10: A `wake_evt` while powered down brings `cpu_hold` back to 0 after `WAKE_CNT`+1 cycles when `osc_ok` is 1, with no `flash_start` and no `vec_zero`. A `wake_evt` while running is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Oscillator-derived clock |
| por_n | input | 1 | Asynchronous power-on reset, active low |
| pin_rst_n | input | 1 | Raw external reset pin, active low |
| wdt_rst | input | 1 | Watchdog reset request, one cycle |
| osc_ok | input | 1 | Oscillator valid flag |
| flash_done | input | 1 | Flash initialization finished |
| pd_req | input | 1 | Enter power-down, one cycle |
| wake_evt | input | 1 | Wake from power-down, one cycle |
| sys_rst_n | output | 1 | Internal chip reset, active low |
| cpu_hold | output | 1 | Core stalled (reset, sequence or power-down) |
| flash_start | output | 1 | One-cycle flash initialization start |
| vec_zero | output | 1 | One-cycle pulse: fetch from address 0 |
| cause | output | 2 | Last reset source: 00 power-on, 01 pin, 10 watchdog |

## Verification
A wrong wake-counter value or a counter that does not stall when `osc_ok` is low would move `flash_start` away from its exact expected cycle, so that error shows up in the first sequence after power-on. A wrong glitch-filter count would either let a three-sample pulse reach `sys_rst_n` within a few cycles or hide a four-sample one. A wrong state after power-down or a watchdog hit would show as `cpu_hold` dropping at the wrong cycle, or as a stray `flash_start` or `vec_zero`.

// File: rtl/rst_wake_seq.sv
module rst_wake_seq #(
  parameter int WAKE_CNT = 4096,
  parameter int FILT_LEN = 4
) (
  input  logic       clk,
  input  logic       por_n,
  input  logic       pin_rst_n,
  input  logic       wdt_rst,
  input  logic       osc_ok,
  input  logic       flash_done,
  input  logic       pd_req,
  input  logic       wake_evt,
  output logic       sys_rst_n,
  output logic       cpu_hold,
  output logic       flash_start,
  output logic       vec_zero,
  output logic [1:0] cause
);
  localparam int CW = $clog2(WAKE_CNT + 1);
  localparam int FW = $clog2(FILT_LEN + 1);

  typedef enum logic [2:0] {S_HOLD, S_COUNT, S_FLASH, S_RUN, S_SLEEP, S_WAKE} st_t;

  st_t st, st_nx;
  logic [1:0]    sync_q;
  logic          pin_q;
  logic [FW-1:0] fcnt;
  logic [CW-1:0] wcnt;
  logic          pin_fall, cnt_done;

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) sync_q <= '0;
    else        sync_q <= {sync_q[0], pin_rst_n};

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) begin
      pin_q <= 1'b0;
      fcnt  <= '0;
    end else if (sync_q[1] == pin_q) begin
      fcnt <= '0;
    end else if (fcnt == FW'(FILT_LEN - 1)) begin
      pin_q <= sync_q[1];
      fcnt  <= '0;
    end else begin
      fcnt <= fcnt + 1'b1;
    end

  assign pin_fall = pin_q && !sync_q[1] && (fcnt == FW'(FILT_LEN - 1));
  assign cnt_done = osc_ok && (wcnt == CW'(WAKE_CNT - 1));

  always_comb begin
    st_nx = st;
    if (!pin_q || wdt_rst) st_nx = S_HOLD;
    else case (st)
      S_HOLD:  st_nx = S_COUNT;
      S_COUNT: if (cnt_done) st_nx = S_FLASH;
      S_FLASH: if (flash_done && !flash_start) st_nx = S_RUN;
      S_RUN:   if (pd_req) st_nx = S_SLEEP;
      S_SLEEP: if (wake_evt) st_nx = S_WAKE;
      S_WAKE:  if (cnt_done) st_nx = S_RUN;
      default: st_nx = S_HOLD;
    endcase
  end

  always_ff @(posedge clk or negedge por_n)
    if (!por_n) begin
      st          <= S_HOLD;
      wcnt        <= '0;
      flash_start <= 1'b0;
      vec_zero    <= 1'b0;
      cause       <= 2'b00;
    end else begin
      st          <= st_nx;
      flash_start <= (st_nx == S_FLASH) && (st != S_FLASH);
      vec_zero    <= (st == S_FLASH) && (st_nx == S_RUN);
      if (st_nx != st)
        wcnt <= '0;
      else if ((st == S_COUNT || st == S_WAKE) && osc_ok)
        wcnt <= wcnt + 1'b1;
      if (pin_fall)     cause <= 2'b01;
      else if (wdt_rst) cause <= 2'b10;
    end

  assign sys_rst_n = (st == S_RUN) || (st == S_SLEEP) || (st == S_WAKE);
  assign cpu_hold  = (st != S_RUN);
endmodule

// File: rtl/rst_wake_seq_chk.sv
module rst_wake_seq_chk (
  input logic clk,
  input logic por_n,
  input logic wdt_rst,
  input logic flash_done,
  input logic pd_req,
  input logic sys_rst_n,
  input logic cpu_hold,
  input logic flash_start,
  input logic vec_zero
);
  p_flash_single_r5: assert property (@(posedge clk) disable iff (!por_n)
    flash_start |=> !flash_start);

  p_release_needs_done_r5: assert property (@(posedge clk) disable iff (!por_n)
    $rose(sys_rst_n) |-> ($past(flash_done) && !$past(flash_start)));

  p_hold_in_reset_r1: assert property (@(posedge clk) disable iff (!por_n)
    !sys_rst_n |-> cpu_hold);

  p_vec_at_release_r6: assert property (@(posedge clk) disable iff (!por_n)
    $rose(sys_rst_n) |-> (vec_zero && !cpu_hold));

  p_vec_only_running_r6: assert property (@(posedge clk) disable iff (!por_n)
    vec_zero |-> (sys_rst_n && !cpu_hold));

  p_wdt_resets_r7: assert property (@(posedge clk) disable iff (!por_n)
    wdt_rst |=> !sys_rst_n);

  p_sleep_holds_r9: assert property (@(posedge clk) disable iff (!por_n)
    (pd_req && !cpu_hold && !wdt_rst) |=> cpu_hold);
endmodule

bind rst_wake_seq rst_wake_seq_chk u_chk (
  .clk(clk), .por_n(por_n), .wdt_rst(wdt_rst), .flash_done(flash_done),
  .pd_req(pd_req), .sys_rst_n(sys_rst_n), .cpu_hold(cpu_hold),
  .flash_start(flash_start), .vec_zero(vec_zero)
);

// File: tb/sim_rst_wake_seq.sv
module sim_rst_wake_seq;
  localparam int W = 32;

  logic clk = 1'b0;
  logic por_n, pin_rst_n, wdt_rst, osc_ok, flash_done, pd_req, wake_evt;
  logic sys_rst_n, cpu_hold, flash_start, vec_zero;
  logic [1:0] cause;
  int nchk = 0, nfail = 0;

  always #5 clk = ~clk;

  rst_wake_seq #(.WAKE_CNT(W), .FILT_LEN(4)) u0 (
    .clk(clk), .por_n(por_n), .pin_rst_n(pin_rst_n), .wdt_rst(wdt_rst),
    .osc_ok(osc_ok), .flash_done(flash_done), .pd_req(pd_req), .wake_evt(wake_evt),
    .sys_rst_n(sys_rst_n), .cpu_hold(cpu_hold), .flash_start(flash_start),
    .vec_zero(vec_zero), .cause(cause));

  // glitch pulse width, 1 = reset expected (R2)
  localparam int NV = 6;
  localparam int VEC [NV][2] = '{'{1,0}, '{2,0}, '{3,0}, '{4,1}, '{6,1}, '{12,1}};

  task automatic check(input bit ok, input string req, input int got, input int exp);
    nchk++;
    if (!ok) begin
      nfail++;
      $display("FAIL %s: got %0d expected %0d", req, got, exp);
    end
  endtask

  task automatic tick(input int n);
    for (int i = 0; i < n; i++) begin
      @(posedge clk);
      @(negedge clk);
    end
  endtask

  task automatic finish_release(input string req);
    int n = 0;
    while (!flash_start && n < 5000) begin tick(1); n++; end
    check(flash_start, req, 0, 1);
    tick(3);
    flash_done = 1'b1;
    tick(1);
    check(sys_rst_n && !cpu_hold && vec_zero, "R6", {sys_rst_n, cpu_hold, vec_zero}, 3'b101);
    tick(1);
    check(!vec_zero, "R6", vec_zero, 0);
    flash_done = 1'b0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    nfail++;
    $display("FAIL watchdog: got hang expected finish");
    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end

  initial begin
    int m;
    bit seen;
    por_n = 0; pin_rst_n = 1; wdt_rst = 0; osc_ok = 0; flash_done = 0;
    pd_req = 0; wake_evt = 0;
    tick(3);
    // R1 reset state
    check(!sys_rst_n && cpu_hold && cause == 2'b00 && !flash_start, "R1",
          {sys_rst_n, cpu_hold, cause, flash_start}, 5'b01000);
    por_n = 1;
    // R4: no progress while oscillator invalid; pd_req ignored in sequence
    seen = 0;
    for (int i = 0; i < 100; i++) begin
      if (i == 40) pd_req = 1;
      if (i == 41) pd_req = 0;
      tick(1);
      if (flash_start || sys_rst_n) seen = 1;
    end
    check(!seen, "R4", seen, 0);
    check(cause == 2'b00, "R1", cause, 0);
    // R4: count with a gap, exact WAKE_CNT oscillator-valid cycles
    osc_ok = 1;
    tick(10);
    osc_ok = 0;
    tick(50);
    check(!flash_start, "R4", flash_start, 0);
    osc_ok = 1;
    m = 10;
    while (!flash_start && m < 1000) begin tick(1); m++; end
    check(m == W, "R4", m, W);
    // R5: done raised in the start cycle is not accepted
    flash_done = 1;
    tick(1);
    check(!flash_start, "R5", flash_start, 0);
    check(!sys_rst_n, "R5", sys_rst_n, 0);
    tick(1);
    check(sys_rst_n && !cpu_hold && vec_zero, "R6", {sys_rst_n, cpu_hold, vec_zero}, 3'b101);
    tick(1);
    check(!vec_zero && sys_rst_n, "R6", vec_zero, 0);
    flash_done = 0;

    // R2 glitch filter table
    for (int v = 0; v < NV; v++) begin
      pin_rst_n = 0;
      tick(VEC[v][0]);
      pin_rst_n = 1;
      tick(10);
      check(sys_rst_n == !VEC[v][1], "R2", sys_rst_n, !VEC[v][1]);
      if (VEC[v][1] != 0) begin
        check(cause == 2'b01, "R8", cause, 1);
        finish_release("R2");
      end
    end

    // R3: long hold keeps reset
    pin_rst_n = 0;
    tick(200);
    check(!sys_rst_n && cpu_hold, "R3", sys_rst_n, 0);
    pin_rst_n = 1;
    finish_release("R3");
    check(cause == 2'b01, "R8", cause, 1);

    // R7 watchdog from running
    wdt_rst = 1;
    tick(1);
    wdt_rst = 0;
    check(!sys_rst_n, "R7", sys_rst_n, 0);
    check(cause == 2'b10, "R8", cause, 2);
    // R7 watchdog mid-count restarts timer
    tick(10);
    wdt_rst = 1;
    tick(1);
    wdt_rst = 0;
    m = 1;
    while (!flash_start && m < 1000) begin tick(1); m++; end
    check(m == W + 2, "R7", m, W + 2);
    finish_release("R7");
    check(cause == 2'b10, "R8", cause, 2);

    // R10: wake while running ignored
    wake_evt = 1;
    tick(1);
    wake_evt = 0;
    check(!cpu_hold, "R10", cpu_hold, 0);
    // R9 power-down
    pd_req = 1;
    tick(1);
    pd_req = 0;
    check(cpu_hold && sys_rst_n, "R9", {cpu_hold, sys_rst_n}, 2'b11);
    tick(20);
    check(cpu_hold && sys_rst_n, "R9", {cpu_hold, sys_rst_n}, 2'b11);
    // R10 wake timing, no flash and no vector pulse
    wake_evt = 1;
    tick(1);
    wake_evt = 0;
    m = 1;
    seen = 0;
    while (cpu_hold && m < 1000) begin
      tick(1); m++;
      if (flash_start || vec_zero) seen = 1;
    end
    if (flash_start || vec_zero) seen = 1;
    check(m == W + 1, "R10", m, W + 1);
    check(!seen && sys_rst_n, "R10", seen, 0);

    // R7 watchdog while powered down
    pd_req = 1;
    tick(1);
    pd_req = 0;
    wdt_rst = 1;
    tick(1);
    wdt_rst = 0;
    check(!sys_rst_n, "R7", sys_rst_n, 0);
    finish_release("R7");

    $display("== %0d vectors applied, %0d miscompares ==", nchk, nfail);
    $finish;
  end
endmodule